// File: doc/BRIEF.md
# Hashed-Counter Hot/Cold Address Classifier

This block decides whether a logical block address (LBA) belongs to frequently rewritten ("hot") data or to rarely rewritten ("cold") data, so that a flash translation layer can group data of similar lifetime. Each written LBA is scrambled by K independent multiplicative hashes into a shared table of M small saturating counters. Many addresses share each counter, so the storage is a fixed M x C bits regardless of the address space.

The block has three operations. A write request bumps the counters the LBA hashes to. In basic mode every indexed counter is bumped. In enhanced mode only the indexed counters that hold the smallest value among them are bumped, which limits how far a cold address can be inflated by neighbours that share its entries. A check request answers hot only when every one of the LBA's K counters has a 1 somewhere in its top H bits. After a programmable number of accepted writes, the block ages the table by walking it one entry per cycle and halving each counter. Both request ports are held off while this walk runs.

The controller has two states. In IDLE both ports are ready. The transition IDLE -> SWEEP is taken on the accepted write that brings the write count to the decay period. In SWEEP, one entry is halved per cycle. The transition SWEEP -> IDLE is taken after the last entry has been halved.

Top module: `hot_id_filter`

## Requirements
- R1: Hash k (k = 0..K-1) maps an LBA to entry index = bits [LBA_W-1 : LBA_W-IDX_W] of (LBA x MUL_k) mod 2^LBA_W, where MUL_k = (0x9E37 + k x 0x3C6E) truncated to LBA_W bits with bit 0 forced to 1. With the defaults, MUL_0 = 0x9E37, MUL_1 = 0xDAA5, and the index is the top 4 bits of the 16-bit product.
- R2: In basic mode (`enh_mode`=0), an accepted write adds one to every entry that any of its K hashes selects.
- R3: In enhanced mode (`enh_mode`=1), an accepted write adds one only to the selected entries whose value equals the minimum over the K selected values.
- R4: Counters saturate at 2^C-1 and never wrap.
- R5: An accepted check produces `res_valid`=1 on the next cycle. In that cycle `res_hot`=1 iff every one of the K selected counters is >= 2^(C-H), where H = min(`hot_bits`, C). H=0 always gives cold. Counters are sampled before any write accepted in the same cycle. `res_hot` is 0 whenever `res_valid` is 0.
- R6: When `decay_period` is nonzero and an accepted write makes the write count reach `decay_period` (count+1 >= period), the count returns to 0 and every counter is halved (right shift by one). A period of 0 disables decay.
- R7: The write that triggers decay is applied first. Starting the next cycle, `upd_ready` and `chk_ready` are both low for exactly M cycles (IDLE -> SWEEP, then SWEEP -> IDLE).
- R8: Synchronous reset clears all counters and the write count. During and after reset both ready outputs are 1 and `res_valid` is 0.
- R9: When several hashes select the same entry, that entry gains at most one per write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enh_mode | input | 1 | 0: bump all selected entries, 1: bump only minimum-valued ones |
| decay_period | input | PER_W | Accepted writes between decays, 0 disables |
| hot_bits | input | HB_W | Number of counter MSBs (H) inspected by the hot test |
| upd_valid | input | 1 | Write-update request |
| upd_lba | input | LBA_W | LBA of the write |
| upd_ready | output | 1 | Write-update port can accept |
| chk_valid | input | 1 | Hotness query request |
| chk_lba | input | LBA_W | LBA to classify |
| chk_ready | output | 1 | Query port can accept |
| res_valid | output | 1 | Query result present (one cycle after acceptance) |
| res_hot | output | 1 | 1 = hot, 0 = cold |

## Verification
Some properties are checked on every cycle:
- a counter only grows by zero or one while the controller is idle (R2, R9);
- a full counter stays full outside the sweep (R4);
- every result follows exactly one accepted query (R5);
- the ports only fall busy right after a write (R7).

Other behaviours only the bench scenarios can show, because they depend on the hash arithmetic and on sequences of writes:
- which entries the hashes select;
- the minimum-only bump;
- the H-bit threshold, including colliding indices;
- the halving after a chosen number of writes;
- the exact length of the busy window.

// File: rtl/hdi_pkg.sv
package hdi_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SWEEP = 1'b1
    } hdi_state_e;
endpackage

// File: rtl/hdi_hash.sv
module hdi_hash #(
    parameter int LBA_W = 16,
    parameter int IDX_W = 4,
    parameter int K     = 2
) (
    input  logic [LBA_W-1:0]   lba,
    output logic [K*IDX_W-1:0] idx
);
    for (genvar k = 0; k < K; k++) begin : g_mix
        localparam logic [31:0]      MUL32 = 32'h9E37 + 32'(k) * 32'h3C6E;
        localparam logic [LBA_W-1:0] MUL   = MUL32[LBA_W-1:0] | LBA_W'(1);
        logic [LBA_W-1:0] prod;
        assign prod = lba * MUL;
        assign idx[k*IDX_W +: IDX_W] = prod[LBA_W-1 -: IDX_W];
    end
endmodule

// File: rtl/hdi_table.sv
module hdi_table #(
    parameter int IDX_W = 4,
    parameter int C     = 4,
    parameter int K     = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 inc_en,
    input  logic                 enh,
    input  logic [K*IDX_W-1:0]   idx,
    input  logic                 halve_en,
    input  logic [IDX_W-1:0]     halve_ptr,
    output logic [(1<<IDX_W)*C-1:0] cnt_flat
);
    localparam int M = 1 << IDX_W;
    localparam logic [C-1:0] CMAX = '1;

    logic [C-1:0] min_val;

    always_comb begin
        min_val = CMAX;
        for (int k = 0; k < K; k++) begin
            if (cnt_flat[int'(idx[k*IDX_W +: IDX_W])*C +: C] < min_val)
                min_val = cnt_flat[int'(idx[k*IDX_W +: IDX_W])*C +: C];
        end
    end

    for (genvar j = 0; j < M; j++) begin : g_ent
        logic [C-1:0] val;
        logic         hit;
        logic         bump;

        always_comb begin
            hit = 1'b0;
            for (int k = 0; k < K; k++)
                if (idx[k*IDX_W +: IDX_W] == IDX_W'(j)) hit = 1'b1;
        end

        assign bump = inc_en && hit && (!enh || val == min_val) && val != CMAX;

        always_ff @(posedge clk) begin
            if (rst)
                val <= '0;
            else if (halve_en && halve_ptr == IDX_W'(j))
                val <= val >> 1;
            else if (bump)
                val <= val + 1'b1;
        end

        assign cnt_flat[j*C +: C] = val;
    end
endmodule

// File: rtl/hot_id_filter.sv
module hot_id_filter #(
    parameter int LBA_W = 16,
    parameter int IDX_W = 4,
    parameter int K     = 2,
    parameter int C     = 4,
    parameter int PER_W = 16,
    parameter int HB_W  = $clog2(C + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enh_mode,
    input  logic [PER_W-1:0] decay_period,
    input  logic [HB_W-1:0]  hot_bits,
    input  logic             upd_valid,
    input  logic [LBA_W-1:0] upd_lba,
    output logic             upd_ready,
    input  logic             chk_valid,
    input  logic [LBA_W-1:0] chk_lba,
    output logic             chk_ready,
    output logic             res_valid,
    output logic             res_hot
);
    import hdi_pkg::*;

    localparam int M = 1 << IDX_W;

    hdi_state_e state, state_nx;
    logic [PER_W-1:0]   wcnt;
    logic [IDX_W-1:0]   ptr;
    logic [K*IDX_W-1:0] uidx, cidx;
    logic [M*C-1:0]     cnt_flat;
    logic               wr_acc, chk_acc, trigger, sweeping, hot_now;
    logic [PER_W-1:0]   wcnt_inc;

    hdi_hash #(.LBA_W(LBA_W), .IDX_W(IDX_W), .K(K)) u_hash_upd (.lba(upd_lba), .idx(uidx));
    hdi_hash #(.LBA_W(LBA_W), .IDX_W(IDX_W), .K(K)) u_hash_chk (.lba(chk_lba), .idx(cidx));

    hdi_table #(.IDX_W(IDX_W), .C(C), .K(K)) u_table (
        .clk      (clk),
        .rst      (rst),
        .inc_en   (wr_acc),
        .enh      (enh_mode),
        .idx      (uidx),
        .halve_en (sweeping),
        .halve_ptr(ptr),
        .cnt_flat (cnt_flat)
    );

    // outputs of the controller
    always_comb begin
        upd_ready = (state == ST_IDLE);
        chk_ready = (state == ST_IDLE);
        sweeping  = (state == ST_SWEEP);
    end

    assign wr_acc   = upd_valid && upd_ready;
    assign chk_acc  = chk_valid && chk_ready;
    assign wcnt_inc = wcnt + 1'b1;
    assign trigger  = wr_acc && (decay_period != '0) && (wcnt_inc >= decay_period);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (trigger) state_nx = ST_SWEEP;
            ST_SWEEP: if (ptr == IDX_W'(M - 1)) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register and sweep/write counters
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            ptr   <= '0;
            wcnt  <= '0;
        end else begin
            state <= state_nx;
            if (sweeping) ptr <= ptr + 1'b1;
            if (wr_acc) wcnt <= trigger ? '0 : wcnt_inc;
        end
    end

    // hot test against the counters before this cycle's update
    always_comb begin
        int h, sh;
        h = (int'(hot_bits) > C) ? C : int'(hot_bits);
        sh = C - h;
        hot_now = (h != 0);
        for (int k = 0; k < K; k++) begin
            if ((cnt_flat[int'(cidx[k*IDX_W +: IDX_W])*C +: C] >> sh) == '0)
                hot_now = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_hot   <= 1'b0;
        end else begin
            res_valid <= chk_acc;
            res_hot   <= chk_acc && hot_now;
        end
    end
endmodule

// File: rtl/hdi_chk.sv
module hdi_chk #(
    parameter int M = 16,
    parameter int C = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         upd_valid,
    input logic         upd_ready,
    input logic         chk_valid,
    input logic         chk_ready,
    input logic         res_valid,
    input logic [M*C-1:0] cnt_flat
);
    localparam logic [C-1:0] CMAX = '1;

    // R5
    res_after_query_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && chk_ready) |=> res_valid);

    // R5
    res_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(chk_valid && chk_ready));

    // R7
    busy_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(upd_ready) |-> $past(upd_valid));

    // R7
    ports_busy_together_chk: assert property (@(posedge clk) disable iff (rst)
        upd_ready == chk_ready);

    for (genvar j = 0; j < M; j++) begin : g_ent
        // R4
        no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
            (upd_ready && cnt_flat[j*C +: C] == CMAX) |=> cnt_flat[j*C +: C] == CMAX);

        // R9
        single_step_chk: assert property (@(posedge clk) disable iff (rst)
            upd_ready |=> (cnt_flat[j*C +: C] == $past(cnt_flat[j*C +: C]) ||
                           cnt_flat[j*C +: C] == $past(cnt_flat[j*C +: C]) + 1'b1));
    end
endmodule

bind hot_id_filter hdi_chk #(.M(M), .C(C)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .upd_valid(upd_valid),
    .upd_ready(upd_ready),
    .chk_valid(chk_valid),
    .chk_ready(chk_ready),
    .res_valid(res_valid),
    .cnt_flat (cnt_flat)
);

// File: tb/sim_hot_id_filter.sv
`timescale 1ns/1ps
module sim_hot_id_filter;
    localparam int LBA_W = 16, IDX_W = 4, K = 2, C = 4, PER_W = 16, HB_W = 3;
    localparam int M = 16, CMAX = 15;

    logic clk = 0, rst = 1;
    logic enh_mode = 0;
    logic [PER_W-1:0] decay_period = '0;
    logic [HB_W-1:0] hot_bits = 3'd2;
    logic upd_valid = 0, chk_valid = 0;
    logic [LBA_W-1:0] upd_lba = '0, chk_lba = '0;
    logic upd_ready, chk_ready, res_valid, res_hot;

    always #2 clk = ~clk;

    hot_id_filter u0 (
        .clk(clk), .rst(rst), .enh_mode(enh_mode), .decay_period(decay_period),
        .hot_bits(hot_bits), .upd_valid(upd_valid), .upd_lba(upd_lba),
        .upd_ready(upd_ready), .chk_valid(chk_valid), .chk_lba(chk_lba),
        .chk_ready(chk_ready), .res_valid(res_valid), .res_hot(res_hot)
    );

    int n_cmp = 0, n_bad = 0;
    string tag = "R8";

    // reference model state
    int cnt[M];
    int wcnt = 0, ptr = 0;
    bit sweep = 0, exp_rv = 0, exp_hot = 0;

    // R1: multiplicative hash, top IDX_W bits of a 16-bit product
    function automatic int hidx(int lba, int k);
        longint mul;
        mul = (k == 0) ? 64'h9E37 : 64'hDAA5;
        return int'(((longint'(lba) * mul) & 64'hFFFF) >> 12);
    endfunction

    function automatic bit model_hot(int lba);
        int h;
        h = (int'(hot_bits) > C) ? C : int'(hot_bits);
        if (h == 0) return 0;
        for (int k = 0; k < K; k++)
            if (cnt[hidx(lba, k)] < (1 << (C - h))) return 0;
        return 1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < M; j++) cnt[j] = 0;
            wcnt = 0; ptr = 0; sweep = 0; exp_rv = 0; exp_hot = 0;
        end else begin
            exp_rv  = chk_valid && !sweep;
            exp_hot = exp_rv && model_hot(int'(chk_lba));
            if (sweep) begin
                cnt[ptr] = cnt[ptr] / 2;
                ptr++;
                if (ptr == M) begin ptr = 0; sweep = 0; end
            end else if (upd_valid) begin
                int a, b, mn;
                bit ia, ib;
                a = hidx(int'(upd_lba), 0);
                b = hidx(int'(upd_lba), 1);
                mn = (cnt[a] < cnt[b]) ? cnt[a] : cnt[b];
                ia = !enh_mode || cnt[a] == mn;
                ib = (b != a) && (!enh_mode || cnt[b] == mn);
                if (ia && cnt[a] < CMAX) cnt[a]++;
                if (ib && cnt[b] < CMAX) cnt[b]++;
                if (decay_period != 0 && wcnt + 1 >= int'(decay_period)) begin
                    wcnt = 0; sweep = 1;
                end else wcnt++;
            end
        end
    end

    task automatic check(string t, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", t, got, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            check({tag, " ready"}, int'(upd_ready), int'(!sweep));
            check({tag, " chk_ready"}, int'(chk_ready), int'(!sweep));
            check({tag, " res_valid"}, int'(res_valid), int'(exp_rv));
            check({tag, " res_hot"}, int'(res_hot), int'(exp_hot));
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        rst = 1; upd_valid = 0; chk_valid = 0;
        step(); step();
        rst = 0;
    endtask

    task automatic write(int lba);
        upd_valid = 1; upd_lba = LBA_W'(lba);
        step();
        upd_valid = 0;
    endtask

    task automatic query(int lba, int exp, string t);
        chk_valid = 1; chk_lba = LBA_W'(lba);
        step();
        chk_valid = 0;
        check({t, " res_valid"}, int'(res_valid), 1);
        check({t, " hot"}, int'(res_hot), exp);
    endtask

    task automatic traffic(int n, int span);
        for (int i = 0; i < n; i++) begin
            upd_valid = 1'($urandom);
            upd_lba   = LBA_W'($urandom % span);
            chk_valid = 1'($urandom);
            chk_lba   = LBA_W'($urandom % span);
            step();
        end
        upd_valid = 0; chk_valid = 0;
    endtask

    int lba_a, lba_col, lows;

    initial begin
        lba_a = 1; lba_col = 0;
        for (int a = 1; a < 4096; a++) if (hidx(a, 0) != hidx(a, 1)) begin lba_a = a; break; end
        for (int a = 0; a < 4096; a++) if (hidx(a, 0) == hidx(a, 1)) begin lba_col = a; break; end

        // R8: reset state
        do_reset();
        tag = "R8";
        check("R8 upd_ready after reset", int'(upd_ready), 1);
        check("R8 chk_ready after reset", int'(chk_ready), 1);
        check("R8 res_valid after reset", int'(res_valid), 0);
        query(lba_a, 0, "R8 cleared table");

        // R2 and R5: basic bumps, threshold 4 with H=2
        tag = "R2";
        hot_bits = 3'd2;
        for (int i = 0; i < 3; i++) write(lba_a);
        query(lba_a, 0, "R2 three writes cold");
        write(lba_a);
        query(lba_a, 1, "R2 four writes hot");
        tag = "R5";
        hot_bits = 3'd0;
        query(lba_a, 0, "R5 H=0 cold");
        hot_bits = 3'd4;
        query(lba_a, 1, "R5 H=4 hot");
        hot_bits = 3'd1;
        query(lba_a, 0, "R5 H=1 cold at 4");

        // R4: saturation
        tag = "R4";
        for (int i = 0; i < 20; i++) write(lba_a);
        query(lba_a, 1, "R4 saturated stays >=8");

        // R6 and R7: decay halves, ports busy M cycles
        tag = "R6";
        decay_period = 16'd1;
        write(lba_a);
        lows = 0;
        for (int i = 0; i < 40; i++) begin
            if (!upd_ready) lows++;
            step();
        end
        check("R7 busy window length", lows, M);
        decay_period = 16'd0;
        hot_bits = 3'd1;
        query(lba_a, 0, "R6 halved to 7 below 8");
        hot_bits = 3'd2;
        query(lba_a, 1, "R6 halved to 7 at least 4");

        // R9: colliding hash indices bump once
        do_reset();
        tag = "R9";
        for (int i = 0; i < 4; i++) write(lba_col);
        hot_bits = 3'd1;
        query(lba_col, 0, "R9 single bump per write");
        hot_bits = 3'd2;
        query(lba_col, 1, "R9 reaches 4");

        // R1, R2: basic-mode mixed traffic
        tag = "R1";
        hot_bits = 3'd2;
        traffic(400, 64);

        // R3: enhanced-mode mixed traffic
        do_reset();
        tag = "R3";
        enh_mode = 1;
        traffic(600, 48);

        // R6, R7: periodic decay under traffic
        tag = "R7";
        decay_period = 16'd7;
        traffic(800, 40);
        enh_mode = 0;
        decay_period = 16'd3;
        hot_bits = 3'd3;
        traffic(600, 32);

        step(); step();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule